// File: doc/BRIEF.md
# Two-Rail Serial Word Transmitter

This block sends 32-bit words on a pair of return-to-null rails. A zero bit raises one rail, a one bit raises the other, and both rails low means null. A bit time is four transmit clocks. The host loads the word one byte at a time through an 8-bit write port. It controls the block through a small control register and reads a status byte through the same port. A clear-to-send input, active low, gates each word, and a line driver outside the block converts the rails to bus levels.

Two loading modes are available. In buffered word mode, all four bytes are loaded before the word may start, and the buffer is locked while the word is on the line. In streaming byte mode, the word starts once the first byte is present, and the host supplies each later byte while the earlier bytes are being shifted out. If the host misses a byte deadline, a sticky underwrite error is set, the word is cut short, and the transmitter refuses to start again until the host reads status. Bit 32 may carry generated odd parity. A self-test setting diverts the bits to a loopback pair and keeps the external rails at null.

Top module: `tw_word_tx`

## Requirements
- R1: After reset, both pairs of rails are null, `tx_busy_n` is 1, `tx_load_rdy` is 1 and `tx_err` is 0. The control register holds 0x61: enable (bit 0) = 1, self test (bit 4) = 0, byte mode (bit 5) = 1, parity (bit 6) = 1. A status read returns 0x05.
- R2: Each bit occupies 4 clocks. The one rail (for a 1) or the zero rail (for a 0) is high for 2 clocks, then both rails are null for 2 clocks. The two rails are never high together.
- R3: The word is formed as {byte3, byte2, byte1, byte0} in load order. Word bit 0 is sent first, and the bits follow in ascending order to bit 31.
- R4: With parity on, the last bit sent is chosen so that the 32 bits hold an odd number of ones. With parity off, the last bit is word bit 31 as loaded.
- R5: In word mode, a word starts only when four bytes are loaded, enable is 1 and `cts_n` is 0. While `cts_n` stays 1 nothing is sent, and a one-cycle low pulse releases the word.
- R6: A control write that changes enable from 0 to 1 starts a word that is already loaded, provided `cts_n` is low.
- R7: `tx_busy_n` is 0 while a word is on the line and 1 otherwise. Status bit 2 reads 1 only when the transmitter is idle.
- R8: Consecutive words are separated by at least 16 clocks (four bit times) of null beyond the null half of the last bit.
- R9: In byte mode, a word starts once one byte is loaded, and the remaining bytes are accepted while the word is being sent.
- R10: In byte mode, if the next byte is not loaded by the end of the 8th bit of the previous byte, `tx_err` and status bit 7 are set and the word stops at that byte boundary.
- R11: While the error is set, nothing is sent and loads are refused. A status read (select = 1, read strobe) clears it, and the transmitter then works again.
- R12: With self test set, the external rails stay null and the loopback rails carry the word with the same timing.
- R13: Status bit 0 and `tx_load_rdy` are 1 when a data byte will be accepted. In word mode they are 0 once four bytes are held or while a word is being sent. A data write while they are 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, four per bit |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_sel_reg | input | 1 | 1 selects control (write) / status (read), 0 selects data bytes |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Status byte, registered on a status read |
| cts_n | input | 1 | Clear to send, active low |
| tx_rail_zero | output | 1 | External rail high for a 0 bit |
| tx_rail_one | output | 1 | External rail high for a 1 bit |
| loop_rail_zero | output | 1 | Self-test rail for 0 bits |
| loop_rail_one | output | 1 | Self-test rail for 1 bits |
| tx_busy_n | output | 1 | Low while a word is on the line |
| tx_load_rdy | output | 1 | A data byte would be accepted |
| tx_err | output | 1 | Sticky underwrite error |

## Verification
The bound assertions are evaluated on every cycle. They cover:
- that the rails are mutually exclusive and that the external and loopback pairs are never active together;
- the two-clock high pulse;
- that the error persists until a status read and blocks any word;
- that busy follows the start of a word;
- that the word-mode buffer is locked during sending;
- that every start comes after a full sixteen-clock idle run.

Only the bench's scenarios can show the remaining behaviour:
- the exact bit order and parity value;
- the gating by clear-to-send and by an enable write;
- the deadline of byte streaming and the point at which the word is cut;
- that refused loads leave the word untouched.

// File: rtl/tw_tx_pkg.sv
package tw_tx_pkg;
  // control register field positions
  localparam int CR_ENABLE   = 0;
  localparam int CR_SELFTEST = 4;
  localparam int CR_BYTEMODE = 5;
  localparam int CR_PARITY   = 6;
  // status register field positions
  localparam int SR_READY = 0;
  localparam int SR_IDLE  = 2;
  localparam int SR_UNDER = 7;

  typedef struct packed {
    logic parity_en;
    logic byte_mode;
    logic self_test;
    logic enable;
  } tx_ctrl_t;

  localparam tx_ctrl_t CTRL_RESET = '{parity_en: 1'b1, byte_mode: 1'b1,
                                      self_test: 1'b0, enable: 1'b1};
endpackage

// File: rtl/tw_tx_ctrl.sv
module tw_tx_ctrl
  import tw_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_sel_reg,
  input  logic [DW-1:0] host_wdata,
  input  logic          load_rdy,
  input  logic          idle,
  input  logic          underwrite,
  output tx_ctrl_t      ctrl,
  output logic          err,
  output logic [DW-1:0] rdata
);
  logic          reg_wr, reg_rd;
  logic [DW-1:0] status;

  assign reg_wr = host_wr & host_sel_reg;
  assign reg_rd = host_rd & host_sel_reg;

  always_comb begin
    status           = '0;
    status[SR_READY] = load_rdy;
    status[SR_IDLE]  = idle;
    status[SR_UNDER] = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= CTRL_RESET;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      if (reg_wr) begin
        ctrl.enable    <= host_wdata[CR_ENABLE];
        ctrl.self_test <= host_wdata[CR_SELFTEST];
        ctrl.byte_mode <= host_wdata[CR_BYTEMODE];
        ctrl.parity_en <= host_wdata[CR_PARITY];
      end
      // a new error wins over a clearing read in the same cycle
      if (underwrite)  err <= 1'b1;
      else if (reg_rd) err <= 1'b0;
      if (reg_rd) rdata <= status;
    end
  end
endmodule

// File: rtl/tw_tx_buffer.sv
module tw_tx_buffer #(
  parameter int DW    = 8,
  parameter int BYTES = 4,
  localparam int CW   = $clog2(BYTES + 1),
  localparam int WB   = DW * BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_req,
  input  logic [DW-1:0] wdata,
  input  logic          byte_mode,
  input  logic          active,
  input  logic          err,
  input  logic          word_clr,
  output logic [WB-1:0] word,
  output logic [CW-1:0] count,
  output logic          load_rdy
);
  logic [DW-1:0] lane_q [BYTES];
  logic          load_stb;

  assign load_rdy = !err && (count < CW'(BYTES)) && (byte_mode || !active);
  assign load_stb = load_req && load_rdy && !word_clr;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                                lane_q[g] <= '0;
      else if (load_stb && count == CW'(g))   lane_q[g] <= wdata;
    end
    assign word[g*DW +: DW] = lane_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (word_clr) count <= '0;
    else if (load_stb) count <= count + 1'b1;
  end
endmodule

// File: rtl/tw_tx_serializer.sv
module tw_tx_serializer #(
  parameter int WORD_BITS = 32,
  parameter int BYTES     = 4,
  parameter int BIT_CLKS  = 4,
  parameter int GAP_BITS  = 4,
  localparam int CW        = $clog2(BYTES + 1),
  localparam int IW        = $clog2(WORD_BITS),
  localparam int PW        = $clog2(BIT_CLKS),
  localparam int BYTE_BITS = WORD_BITS / BYTES,
  localparam int BSH       = $clog2(BYTE_BITS),
  localparam int GAP_CLKS  = GAP_BITS * BIT_CLKS,
  localparam int GW        = $clog2(GAP_CLKS + 1),
  localparam int HIGH_CLKS = BIT_CLKS / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WORD_BITS-1:0] word,
  input  logic [CW-1:0]        count,
  input  logic                 enable,
  input  logic                 byte_mode,
  input  logic                 parity_en,
  input  logic                 self_test,
  input  logic                 cts_n,
  input  logic                 err,
  output logic                 active,
  output logic                 word_done,
  output logic                 underwrite,
  output logic                 rail_zero,
  output logic                 rail_one,
  output logic                 loop_zero,
  output logic                 loop_one,
  output logic                 busy_n
);
  logic [IW-1:0] bit_idx;
  logic [PW-1:0] phase;
  logic [GW-1:0] gap_cnt;
  logic          have_data, start, last_phase, byte_end, cur_bit, drive;

  assign have_data  = byte_mode ? (count != '0) : (count == CW'(BYTES));
  assign start      = !active && enable && !cts_n && !err &&
                      (gap_cnt == GW'(GAP_CLKS)) && have_data;
  assign last_phase = (phase == PW'(BIT_CLKS - 1));
  assign byte_end   = last_phase && (&bit_idx[BSH-1:0]);
  assign word_done  = active && last_phase && (bit_idx == IW'(WORD_BITS - 1));
  // the byte after the one just finished must already be held
  assign underwrite = active && byte_mode && byte_end && !word_done &&
                      (int'(count) < int'(bit_idx[IW-1:BSH]) + 2);
  assign cur_bit    = (parity_en && bit_idx == IW'(WORD_BITS - 1)) ?
                      ~^word[WORD_BITS-2:0] : word[bit_idx];
  assign drive      = active && (int'(phase) < HIGH_CLKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      bit_idx <= '0;
      phase   <= '0;
      gap_cnt <= GW'(GAP_CLKS);
    end else if (start) begin
      active  <= 1'b1;
      bit_idx <= '0;
      phase   <= '0;
    end else if (active) begin
      if (word_done || underwrite) begin
        active  <= 1'b0;
        gap_cnt <= '0;
      end else if (last_phase) begin
        phase   <= '0;
        bit_idx <= bit_idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end else if (gap_cnt != GW'(GAP_CLKS)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_zero <= 1'b0;
      rail_one  <= 1'b0;
      loop_zero <= 1'b0;
      loop_one  <= 1'b0;
      busy_n    <= 1'b1;
    end else begin
      rail_one  <= drive &&  cur_bit && !self_test;
      rail_zero <= drive && !cur_bit && !self_test;
      loop_one  <= drive &&  cur_bit &&  self_test;
      loop_zero <= drive && !cur_bit &&  self_test;
      busy_n    <= !active;
    end
  end
endmodule

// File: rtl/tw_word_tx.sv
module tw_word_tx
  import tw_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int BIT_CLKS   = 4,
  parameter int GAP_BITS   = 4,
  localparam int WORD_BITS = DATA_W * WORD_BYTES,
  localparam int CW        = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel_reg,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cts_n,
  output logic              tx_rail_zero,
  output logic              tx_rail_one,
  output logic              loop_rail_zero,
  output logic              loop_rail_one,
  output logic              tx_busy_n,
  output logic              tx_load_rdy,
  output logic              tx_err
);
  tx_ctrl_t               ctrl;
  logic [WORD_BITS-1:0]   word;
  logic [CW-1:0]          count;
  logic                   ser_active, word_done, underwrite, mode_byte;

  assign mode_byte = ctrl.byte_mode;

  tw_tx_ctrl #(.DW(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel_reg(host_sel_reg), .host_wdata(host_wdata),
    .load_rdy(tx_load_rdy), .idle(!ser_active), .underwrite(underwrite),
    .ctrl(ctrl), .err(tx_err), .rdata(host_rdata)
  );

  tw_tx_buffer #(.DW(DATA_W), .BYTES(WORD_BYTES)) u_buf (
    .clk(clk), .rst(rst), .load_req(host_wr && !host_sel_reg),
    .wdata(host_wdata), .byte_mode(mode_byte), .active(ser_active),
    .err(tx_err), .word_clr(word_done || underwrite),
    .word(word), .count(count), .load_rdy(tx_load_rdy)
  );

  tw_tx_serializer #(.WORD_BITS(WORD_BITS), .BYTES(WORD_BYTES),
                     .BIT_CLKS(BIT_CLKS), .GAP_BITS(GAP_BITS)) u_ser (
    .clk(clk), .rst(rst), .word(word), .count(count),
    .enable(ctrl.enable), .byte_mode(mode_byte), .parity_en(ctrl.parity_en),
    .self_test(ctrl.self_test), .cts_n(cts_n), .err(tx_err),
    .active(ser_active), .word_done(word_done), .underwrite(underwrite),
    .rail_zero(tx_rail_zero), .rail_one(tx_rail_one),
    .loop_zero(loop_rail_zero), .loop_one(loop_rail_one), .busy_n(tx_busy_n)
  );
endmodule

// File: rtl/tw_word_tx_chk.sv
module tw_word_tx_chk #(
  parameter int GAP_CLKS = 16,
  localparam int GW = $clog2(GAP_CLKS + 1)
) (
  input logic clk,
  input logic rst,
  input logic tx_rail_zero,
  input logic tx_rail_one,
  input logic loop_rail_zero,
  input logic loop_rail_one,
  input logic tx_busy_n,
  input logic tx_load_rdy,
  input logic tx_err,
  input logic host_rd,
  input logic host_sel_reg,
  input logic active,
  input logic byte_mode
);
  logic [GW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst)                          idle_cnt <= GW'(GAP_CLKS);
    else if (active)                  idle_cnt <= '0;
    else if (idle_cnt != GW'(GAP_CLKS)) idle_cnt <= idle_cnt + 1'b1;
  end

  p_rails_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(tx_rail_zero && tx_rail_one) && !(loop_rail_zero && loop_rail_one));
  p_high_two_clks_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_rail_one) |=> tx_rail_one);
  p_ext_null_in_loop_r12: assert property (@(posedge clk) disable iff (rst)
    !((tx_rail_zero || tx_rail_one) && (loop_rail_zero || loop_rail_one)));
  p_busy_follows_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |=> !tx_busy_n);
  p_gap_before_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> idle_cnt == GW'(GAP_CLKS));
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (tx_err && !(host_rd && host_sel_reg)) |=> tx_err);
  p_err_halts_r11: assert property (@(posedge clk) disable iff (rst)
    tx_err |-> !active);
  p_word_lock_r13: assert property (@(posedge clk) disable iff (rst)
    (active && !byte_mode) |-> !tx_load_rdy);
endmodule

bind tw_word_tx tw_word_tx_chk #(.GAP_CLKS(GAP_BITS * BIT_CLKS)) u_chk (
  .clk(clk), .rst(rst), .tx_rail_zero(tx_rail_zero), .tx_rail_one(tx_rail_one),
  .loop_rail_zero(loop_rail_zero), .loop_rail_one(loop_rail_one),
  .tx_busy_n(tx_busy_n), .tx_load_rdy(tx_load_rdy), .tx_err(tx_err),
  .host_rd(host_rd), .host_sel_reg(host_sel_reg), .active(ser_active),
  .byte_mode(mode_byte)
);

// File: tb/sim_tw_word_tx.sv
module sim_tw_word_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       host_wr = 0, host_rd = 0, host_sel_reg = 0, cts_n = 1;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       tx_rail_zero, tx_rail_one, loop_rail_zero, loop_rail_one;
  logic       tx_busy_n, tx_load_rdy, tx_err;

  int checks = 0, errors = 0, matched = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_word_tx u0 (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  bit        use_loop = 0;
  int        bitcnt = 0, high_cnt = 0, null_cnt = 1000, partial_bits = 0;
  int        bits_total = 0, ext_high = 0;
  bit        seen_word = 0;
  logic [31:0] got = '0;

  always @(negedge clk) begin
    if (!rst) begin
      logic z, o;
      z = use_loop ? loop_rail_zero : tx_rail_zero;
      o = use_loop ? loop_rail_one  : tx_rail_one;
      if (tx_rail_zero || tx_rail_one) ext_high++;
      if (z || o) begin
        if (z && o) check(0, "R2 both rails high", 1, 0);
        if (high_cnt == 0) begin
          if (bitcnt > 0) check(null_cnt == 2, "R2 null half", null_cnt, 2);
          else if (seen_word) check(null_cnt >= 18, "R8 word gap", null_cnt, 18);
          got[bitcnt] = o;
          bitcnt++;
          bits_total++;
        end
        high_cnt++;
        null_cnt = 0;
      end else begin
        if (high_cnt > 0) check(high_cnt == 2, "R2 high half", high_cnt, 2);
        high_cnt = 0;
        null_cnt++;
        if (bitcnt == 32) begin
          if (exp_q.size() == 0) check(0, "R3 R4 unexpected word", got, 0);
          else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(got == e, "R3 R4 word", got, e);
            if (got == e) matched++;
          end
          bitcnt = 0;
          seen_word = 1;
        end else if (bitcnt > 0 && null_cnt >= 12) begin
          partial_bits = bitcnt;
          bitcnt = 0;
          seen_word = 1;
        end
      end
    end
  end

  // ---------------- driver ----------------
  function automatic logic [31:0] expw(input logic [31:0] d, input bit par);
    return par ? {~^d[30:0], d[30:0]} : d;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    host_sel_reg = sel; host_wr = 1; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    host_sel_reg = 1; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    v = host_rdata;
  endtask

  task automatic load_word(input logic [31:0] d, input bit par);
    exp_q.push_back(expw(d, par));
    for (int i = 0; i < 4; i++) wr(0, d[i*8 +: 8]);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] st;
    int m0, b0;
    cyc(3);
    rst = 0;
    cyc(1);
    // R1 reset state
    check(!tx_rail_zero && !tx_rail_one && !loop_rail_zero && !loop_rail_one,
          "R1 rails null", {tx_rail_zero, tx_rail_one}, 0);
    check(tx_busy_n && tx_load_rdy && !tx_err, "R1 flags",
          {tx_busy_n, tx_load_rdy, tx_err}, 3'b110);
    rd_status(st);
    check(st == 8'h05, "R1 status", st, 8'h05);

    // R9 byte mode from reset defaults (parity on), streaming bytes
    cts_n = 0;
    exp_q.push_back(expw(32'h3C_96_A5_5A, 1));
    wr(0, 8'h5A);
    cyc(4);
    check(!tx_busy_n, "R7 R9 busy after first byte", tx_busy_n, 0);
    rd_status(st);
    check(st == 8'h01, "R7 R9 status busy and ready", st, 8'h01);
    cyc(4); wr(0, 8'hA5);
    cyc(4); wr(0, 8'h96);
    cyc(4); wr(0, 8'h3C);
    cyc(200);
    check(matched == 1 && exp_q.size() == 0, "R9 streamed word", matched, 1);
    check(tx_busy_n, "R7 idle after word", tx_busy_n, 1);

    // R5 R13 word mode, cts held high, extra write ignored, pulse release
    wr(1, 8'h41);
    cts_n = 1;
    load_word(32'h0000_0007, 1);
    check(!tx_load_rdy, "R13 full buffer not ready", tx_load_rdy, 0);
    wr(0, 8'hFF);
    b0 = bits_total;
    cyc(60);
    check(bits_total == b0 && tx_busy_n, "R5 held by cts", bits_total - b0, 0);
    @(negedge clk); cts_n = 0;
    @(negedge clk); cts_n = 1;
    cyc(200);
    check(matched == 2 && exp_q.size() == 0, "R5 R13 released word", matched, 2);

    // R8 two words back to back, cts held low; R4 parity on
    cts_n = 0;
    load_word(32'hFFFF_FFFF, 1);
    cyc(2);
    while (!tx_load_rdy) cyc(1);
    load_word(32'h8000_0001, 1);
    cyc(220);
    check(matched == 4, "R8 back-to-back words", matched, 4);

    // R4 parity off: bit 32 is data
    wr(1, 8'h01);
    load_word(32'h8000_0003, 0);
    cyc(200);
    check(matched == 5, "R4 parity off word", matched, 5);

    // R6 enable 0 -> 1 start
    wr(1, 8'h40);
    load_word(32'h1234_5678, 1);
    b0 = bits_total;
    cyc(50);
    check(bits_total == b0, "R6 disabled holds", bits_total - b0, 0);
    wr(1, 8'h41);
    cyc(200);
    check(matched == 6, "R6 enable write starts", matched, 6);

    // R10 R11 underwrite in byte mode
    wr(1, 8'h61);
    partial_bits = 0;
    wr(0, 8'hC3);
    cyc(70);
    check(tx_err, "R10 error set", tx_err, 1);
    check(partial_bits == 8, "R10 word cut after byte", partial_bits, 8);
    check(tx_busy_n, "R10 line idle", tx_busy_n, 1);
    b0 = bits_total;
    wr(0, 8'h11);
    cyc(60);
    check(bits_total == b0 && !tx_load_rdy, "R11 halted", bits_total - b0, 0);
    rd_status(st);
    check(st == 8'h84, "R10 status underwrite", st, 8'h84);
    check(!tx_err, "R11 cleared by read", tx_err, 0);
    rd_status(st);
    check(st == 8'h05, "R11 status after clear", st, 8'h05);
    load_word(32'h0F0F_F0F0, 1);
    cyc(200);
    check(matched == 7, "R11 resumes", matched, 7);

    // R12 self test
    wr(1, 8'h51);
    use_loop = 1;
    m0 = ext_high;
    load_word(32'hDEAD_BEEF, 1);
    cyc(200);
    check(matched == 8, "R12 loopback word", matched, 8);
    check(ext_high == m0, "R12 external null", ext_high - m0, 0);
    check(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);

    finish_run();
  end
endmodule